// File: doc/BRIEF.md
# Undefined-Address Fault Trap

This block sits on the memory ports of a small 8-bit processor core. It checks every program and data address against the memory that is actually implemented. Reads that fall outside that memory do not reach the core as floating or aliased bytes. The block replaces them with fixed fill bytes instead. A program read outside the implemented range yields 8'h00. A data read outside the implemented range yields 8'hFF.

The block also watches opcode fetches. When a fetched opcode is 8'h00, the software-interrupt code, it raises a trap request for the core's interrupt logic. The two fill values are chosen to work together, so no separate comparator is needed for either fault:

- A runaway fetch into unimplemented program space reads 00 and therefore traps.
- A return with an empty stack pops two FF bytes from above the top of data memory. The core then fetches from 16'hFFFF, which is outside program memory, so that fetch also traps.

Top module: `undef_addr_trap`

## Requirements
- R1: A program read at an address below `PROG_LIMIT` returns the program array byte `pmem_raw` unchanged on `pmem_out` in the same cycle.
- R2: A program read at an address at or above `PROG_LIMIT` returns 8'h00 on `pmem_out`, whatever the array drives.
- R3: A data read at an address below `DATA_LIMIT` returns the data array byte `dmem_raw` unchanged on `dmem_out` in the same cycle.
- R4: A data read at an address at or above `DATA_LIMIT` returns 8'hFF on `dmem_out`, whatever the array drives.
- R5: The last implemented address (limit minus one) counts as implemented, and the limit address itself does not. This holds for both program and data space.
- R6: When `fetch_stb` is high and the byte on `pmem_out` is the software-interrupt opcode 8'h00, `trap_req` is high for exactly the following cycle. Back-to-back such fetches give back-to-back pulses.
- R7: A program read that returns 8'h00 while `fetch_stb` is low does not raise `trap_req`.
- R8: A fetch whose opcode on `pmem_out` is not 8'h00 does not raise `trap_req`.
- R9: The stack grows downward, and the stack pointer starts at `DATA_LIMIT-1`. A return pops the low byte first and the high byte second, incrementing the pointer before each read. A return with an empty stack therefore forms address 16'hFFFF, and fetching from that address traps.
- R10: While `rst_n` is low and in the first cycle after it is released, `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stb | input | 1 | The current program read is an opcode fetch |
| pc_addr | input | PADDR_W | Program memory address |
| pmem_raw | input | 8 | Byte from the program array |
| pmem_out | output | 8 | Program byte delivered to the core |
| dmem_addr | input | DADDR_W | Data memory address |
| dmem_raw | input | 8 | Byte from the data array |
| dmem_out | output | 8 | Data byte delivered to the core |
| trap_req | output | 1 | Single-cycle software-interrupt request |

## Verification
The program fill path and the data fill path can both act in the same cycle. The bench provokes this by driving an out-of-range fetch and an out-of-range data read together, with nonzero bytes on both arrays. It then judges both fill bytes in that cycle and the trap pulse in the next cycle.

A fetch and an in-range program read of a 00 byte can also look alike at the ports. The bench drives the same 00 byte with and without `fetch_stb`, so that only the strobe separates a trap from a plain constant read.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SWI_OPCODE = 8'h00;
  localparam logic [BYTE_W-1:0] PROG_FILL  = 8'h00;
  localparam logic [BYTE_W-1:0] DATA_FILL  = 8'hFF;

  // address counts as implemented when strictly below the limit
  function automatic logic below_limit(input logic [31:0] addr, input logic [31:0] limit);
    return addr < limit;
  endfunction

  function automatic logic is_swi(input logic [BYTE_W-1:0] op);
    return op == SWI_OPCODE;
  endfunction
endpackage

// File: rtl/addr_window.sv
module addr_window #(
  parameter int W     = 16,
  parameter int LIMIT = 4096
) (
  input  logic [W-1:0] addr,
  output logic         hit
);
  localparam longint SPAN = longint'(1) << W;

  generate
    if (longint'(LIMIT) >= SPAN) begin : g_full
      assign hit = 1'b1;
    end else begin : g_part
      assign hit = trap_pkg::below_limit(32'(addr), 32'(LIMIT));
    end
  endgenerate
endmodule

// File: rtl/fill_mux.sv
module fill_mux #(
  parameter logic [7:0] FILL = 8'h00
) (
  input  logic       hit,
  input  logic [7:0] raw,
  output logic [7:0] rd
);
  always_comb begin
    rd = hit ? raw : FILL;
  end
endmodule

// File: rtl/swi_detect.sv
module swi_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch,
  input  logic [7:0] opcode,
  output logic       trap
);
  logic swi_seen;
  assign swi_seen = fetch && trap_pkg::is_swi(opcode);

  always_ff @(posedge clk) begin
    if (!rst_n) trap <= 1'b0;
    else        trap <= swi_seen;
  end

  // R10: no request in the first cycle out of reset
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !trap);
endmodule

// File: rtl/undef_addr_trap.sv
module undef_addr_trap #(
  parameter int PADDR_W    = 16,
  parameter int DADDR_W    = 8,
  parameter int PROG_LIMIT = 4096,
  parameter int DATA_LIMIT = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_stb,
  input  logic [PADDR_W-1:0] pc_addr,
  input  logic [7:0]         pmem_raw,
  output logic [7:0]         pmem_out,
  input  logic [DADDR_W-1:0] dmem_addr,
  input  logic [7:0]         dmem_raw,
  output logic [7:0]         dmem_out,
  output logic               trap_req
);
  import trap_pkg::*;

  logic prog_hit;
  logic data_hit;

  addr_window #(.W(PADDR_W), .LIMIT(PROG_LIMIT)) u_prog_win (
    .addr(pc_addr), .hit(prog_hit));

  addr_window #(.W(DADDR_W), .LIMIT(DATA_LIMIT)) u_data_win (
    .addr(dmem_addr), .hit(data_hit));

  fill_mux #(.FILL(PROG_FILL)) u_prog_fill (
    .hit(prog_hit), .raw(pmem_raw), .rd(pmem_out));

  fill_mux #(.FILL(DATA_FILL)) u_data_fill (
    .hit(data_hit), .raw(dmem_raw), .rd(dmem_out));

  swi_detect u_swi (
    .clk(clk), .rst_n(rst_n), .fetch(fetch_stb),
    .opcode(pmem_out), .trap(trap_req));

  // R2: decoder miss seen through the fill path yields the fill byte
  a_r2_prog_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_hit |-> pmem_out == PROG_FILL);

  // R4: decoder miss on data side yields all ones
  a_r4_data_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !data_hit |-> dmem_out == DATA_FILL);

  // R9: any fetch outside program memory must end in a trap next cycle
  a_r9_runaway_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !prog_hit) |=> trap_req);

  // R7: a request only ever follows a fetch
  a_r7_only_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(fetch_stb));

  // R8: a request only ever follows the interrupt opcode
  a_r8_only_after_swi: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(pmem_out) == SWI_OPCODE);

  // R6: a swi fetch always gives a request next cycle
  a_r6_swi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && pmem_out == SWI_OPCODE) |=> trap_req);
endmodule

// File: tb/undef_addr_trap_test.sv
module undef_addr_trap_test;
  localparam int PS = 4096;
  localparam int DS = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_stb = 1'b0;
  logic [15:0] pc_addr = '0;
  logic [7:0] pmem_raw = '0;
  logic [7:0] pmem_out;
  logic [7:0] dmem_addr = '0;
  logic [7:0] dmem_raw = '0;
  logic [7:0] dmem_out;
  logic       trap_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic trap; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  undef_addr_trap uut (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .pc_addr(pc_addr),
    .pmem_raw(pmem_raw), .pmem_out(pmem_out), .dmem_addr(dmem_addr),
    .dmem_raw(dmem_raw), .dmem_out(dmem_out), .trap_req(trap_req));

  function automatic logic [7:0] want_prog(input logic [15:0] a, input logic [7:0] r);
    if (int'(a) < PS) return r;
    return 8'h00;
  endfunction

  function automatic logic [7:0] want_data(input logic [7:0] a, input logic [7:0] r);
    if (int'(a) < DS) return r;
    return 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, check combinational outputs, queue the expected trap
  task automatic step(input logic f, input logic [15:0] pa, input logic [7:0] pr,
                      input logic [7:0] da, input logic [7:0] dr, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    fetch_stb = f; pc_addr = pa; pmem_raw = pr; dmem_addr = da; dmem_raw = dr;
    #0.5;
    check({tag, " prog byte"}, {8'h00, pmem_out}, {8'h00, want_prog(pa, pr)});
    check({tag, " data byte"}, {8'h00, dmem_out}, {8'h00, want_data(da, dr)});
    e.trap = f && (want_prog(pa, pr) == 8'h00);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: compares the registered request one cycle after its cause
  always @(posedge clk) begin
    #3;
    if (rst_n && sb.size() > 1) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " trap"}, {15'd0, trap_req}, {15'd0, e.trap});
    end
  end

  // stand-in for the core's return sequence: returns the popped address
  task automatic do_return(inout int sp, output logic [15:0] ret, input logic [7:0] lo_raw,
                           input logic [7:0] hi_raw, input string tag);
    logic [7:0] lo, hi;
    sp++;
    step(1'b0, 16'h0010, 8'h33, 8'(sp), lo_raw, tag);
    lo = dmem_out;
    sp++;
    step(1'b0, 16'h0011, 8'h34, 8'(sp), hi_raw, tag);
    hi = dmem_out;
    ret = {hi, lo};
  endtask

  initial begin
    int sp;
    logic [15:0] ret;
    // R10: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R10 in reset", {15'd0, trap_req}, 16'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    #2 check("R10 after release", {15'd0, trap_req}, 16'd0);

    // R1, R3: in-range pass-through
    step(1'b1, 16'h0100, 8'hA5, 8'h10, 8'h3C, "R1");
    step(1'b0, 16'h0200, 8'h7E, 8'h20, 8'hC3, "R3");
    // R2, R4: out-of-range fills, nonzero array bytes
    step(1'b0, 16'h2000, 8'h5A, 8'hC0, 8'h12, "R2");
    step(1'b0, 16'h1234, 8'h99, 8'h90, 8'h00, "R4");
    // R5: boundaries
    step(1'b1, 16'(PS-1), 8'h44, 8'(DS-1), 8'h55, "R5");
    step(1'b1, 16'(PS), 8'h44, 8'(DS), 8'h55, "R5");
    // R6: swi fetch in range, then back-to-back
    step(1'b1, 16'h0040, 8'h00, 8'h00, 8'h01, "R6");
    step(1'b1, 16'h0041, 8'h00, 8'h01, 8'h02, "R6");
    step(1'b1, 16'h0042, 8'h00, 8'h02, 8'h03, "R6");
    step(1'b0, 16'h0043, 8'h11, 8'h03, 8'h04, "R6");
    // R7: same 00 byte without a fetch, in and out of range
    step(1'b0, 16'h0040, 8'h00, 8'h00, 8'h01, "R7");
    step(1'b0, 16'hF000, 8'hEE, 8'h05, 8'h01, "R7");
    // R8: nonzero opcodes
    step(1'b1, 16'h0050, 8'h01, 8'h05, 8'h06, "R8");
    step(1'b1, 16'h0051, 8'hFF, 8'h06, 8'h07, "R8");
    // simultaneous: runaway fetch plus out-of-range data read
    step(1'b1, 16'h8000, 8'hB7, 8'hFE, 8'h6D, "R2 R4");
    step(1'b0, 16'h0000, 8'h20, 8'h00, 8'h00, "R4");

    // R9: balanced return from stack holding 0x0123
    sp = DS - 3;
    do_return(sp, ret, 8'h23, 8'h01, "R9");
    check("R9 balanced ret", ret, 16'h0123);
    step(1'b1, ret, 8'h6A, 8'h00, 8'h00, "R9");
    // R9: empty-stack return from the top
    sp = DS - 1;
    do_return(sp, ret, 8'h23, 8'h01, "R9");
    check("R9 underflow ret", ret, 16'hFFFF);
    step(1'b1, ret, 8'h6A, 8'h00, 8'h00, "R9");
    step(1'b0, 16'h0000, 8'h20, 8'h00, 8'h00, "R9");
    step(1'b0, 16'h0000, 8'h20, 8'h00, 8'h00, "R9");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule